// File: doc/BRIEF.md
# I2C Master Start/Stop Condition and Bus-Busy Controller

This block is the control part of an I2C master. Software sets the master and transmit mode bits. It then issues a single register write that carries a bus-busy value and a no-condition strobe. A write with the strobe low and busy high produces a start condition on a free bus. If this master already owns the bus, the same write produces a repeated start. A write with the strobe low and busy low releases the bus with a stop condition. A write with the strobe high only updates the mode bits. The SCL and SDA lines are driven open-drain: an output enable of 1 pulls the line low.

A monitor watches both lines through two-flop synchronizers. It sets the busy flag when it sees any start condition and clears it on any stop condition, whichever device drives the bus. A per-byte acknowledge input from the byte shifter can halt continuous transfer when the slave answers high. This halting can be switched off. Setup and hold widths of the generated conditions are counted in clock cycles.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: With master and transmit mode already set, the bus free and the bus not owned, a write with no-cond=0 and busy=1 first keeps both lines released for SETUP_CYC cycles. It then pulls SDA low with SCL released for HOLD_CYC cycles, and then pulls SCL low. `cond_done` rises exactly SETUP_CYC+HOLD_CYC clock edges after the write edge.
- R2: While the bus is owned, the same write gives a repeated start. SDA is released while SCL stays low, then the start sequence of R1 runs. `cond_done` rises 2*SETUP_CYC+HOLD_CYC edges after the write edge, and both lines end pulled low.
- R3: While the bus is owned, a write with no-cond=0, busy=0 and master mode set gives a stop. SCL is released after SETUP_CYC cycles and SDA after another SETUP_CYC cycles. `cond_done` rises 2*SETUP_CYC edges after the write edge, both lines end released and `rd_bus_busy` returns to 0. When the bus is not owned, the write produces no condition.
- R4: A write with no-cond=1 produces no condition and leaves the line drive and `rd_bus_busy` unchanged. `rd_no_cond` always reads 1.
- R5: When the master bit held before the write is 0, a write with no-cond=0 produces no condition, whatever the busy value.
- R6: A start or repeated-start request is ignored unless both the master and transmit bits were already 1 before the write.
- R7: `rd_bus_busy` becomes 1 after SDA falls while SCL is high. It becomes 0 after SDA rises while SCL is high. Both lines pass a two-flop synchronizer first, and the rule holds for conditions driven by any device.
- R8: With ack-halt mode off, a high acknowledge is ignored: `rd_nack_seen` reads 0 and `xfer_go` stays 1.
- R9: With ack-halt mode on, an `ack_valid` pulse with `ack_bit`=1 latches a flag. `rd_nack_seen` then reads 1 and `xfer_go` drops to 0. The flag holds until the next accepted start or repeated start.
- R10: `cond_done` is a single-cycle pulse.
- R11: A start request while another device holds the bus (busy=1, not owned) is ignored.
- R12: After reset both line enables are 0, busy, nack and done read 0, and `xfer_go` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_master | input | 1 | Master mode value written |
| wr_xmit | input | 1 | Transmit mode value written |
| wr_ack_halt | input | 1 | Ack-halt mode value written |
| wr_bus_busy | input | 1 | Busy value written (1 start, 0 stop) |
| wr_no_cond | input | 1 | 1 = write produces no condition |
| rd_master | output | 1 | Master mode bit |
| rd_xmit | output | 1 | Transmit mode bit |
| rd_ack_halt | output | 1 | Ack-halt mode bit |
| rd_bus_busy | output | 1 | Bus busy flag |
| rd_no_cond | output | 1 | Always 1 |
| rd_nack_seen | output | 1 | Latched high acknowledge (ack-halt on) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| ack_valid | input | 1 | Per-byte acknowledge strobe from shifter |
| ack_bit | input | 1 | Received acknowledge level |
| xfer_go | output | 1 | Continuous transfer permitted |
| cond_done | output | 1 | One-cycle pulse at end of a generated start or stop |

## Verification
Some rules are checked by the assertions on every cycle. SDA is never pulled low over a released SCL unless SCL was already released in the previous cycle. The done strobe never lasts two cycles. Any observed start or stop moves the busy flag. A latched high acknowledge stays until cleared. Writes with the strobe set, or made in slave mode, never move the sequencer. Other properties only the bench scenarios can show: the exact done latency of start, repeated start and stop; that requests are refused on a bus held by another device or without transmit mode; and the acknowledge behaviour under both settings of the halt bit. The bench computes these against its own model of ownership and busy state over directed and random operation mixes.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RS_SDA,
        SQ_SETUP,
        SQ_HOLD,
        SQ_OWNED,
        SQ_SP_LOW,
        SQ_SP_SCL
    } seq_state_e;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_START,
        REQ_RESTART,
        REQ_STOP
    } cond_req_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    typedef struct packed {
        logic master;
        logic xmit;
        logic ack_halt;
    } ctrl_reg_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Open-drain drive pattern for each sequencer state
    function automatic line_drive_t drive_for(input seq_state_e s);
        line_drive_t d;
        case (s)
            SQ_RS_SDA: d = '{scl_low: 1'b1, sda_low: 1'b0};
            SQ_HOLD:   d = '{scl_low: 1'b0, sda_low: 1'b1};
            SQ_OWNED:  d = '{scl_low: 1'b1, sda_low: 1'b1};
            SQ_SP_LOW: d = '{scl_low: 1'b1, sda_low: 1'b1};
            SQ_SP_SCL: d = '{scl_low: 1'b0, sda_low: 1'b1};
            default:   d = '{scl_low: 1'b0, sda_low: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_cond_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic busy
);
    logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
    logic scl_prev_q, sda_prev_q, busy_q;
    logic scl_s, sda_s, start_seen, stop_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
            sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_s      = scl_sync_q[SYNC_STAGES-1];
    assign sda_s      = sda_sync_q[SYNC_STAGES-1];
    assign start_seen = scl_s && scl_prev_q && sda_prev_q && !sda_s;
    assign stop_seen  = scl_s && scl_prev_q && !sda_prev_q && sda_s;

    always_ff @(posedge clk) begin
        if (rst)             busy_q <= 1'b0;
        else if (start_seen) busy_q <= 1'b1;
        else if (stop_seen)  busy_q <= 1'b0;
    end

    assign busy = busy_q;

    // R7
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> busy_q);
    // R7
    stop_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !busy_q);
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_cond_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 4,
    parameter int unsigned HOLD_CYC  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  cond_req_e   req,
    output line_drive_t drive,
    output logic        done,
    output logic        idle,
    output logic        owned
);
    localparam int unsigned CNT_W = $clog2(max2(SETUP_CYC, HOLD_CYC) + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             expire;

    assign expire = (state_q == SQ_HOLD) ? (cnt_q == HOLD_LAST) : (cnt_q == SETUP_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    cnt_q <= '0;
                    if (req == REQ_START) state_q <= SQ_SETUP;
                end
                SQ_OWNED: begin
                    cnt_q <= '0;
                    if (req == REQ_RESTART)   state_q <= SQ_RS_SDA;
                    else if (req == REQ_STOP) state_q <= SQ_SP_LOW;
                end
                default: begin
                    if (!expire) begin
                        cnt_q <= cnt_q + 1'b1;
                    end else begin
                        cnt_q <= '0;
                        case (state_q)
                            SQ_RS_SDA: state_q <= SQ_SETUP;
                            SQ_SETUP:  state_q <= SQ_HOLD;
                            SQ_HOLD: begin
                                state_q <= SQ_OWNED;
                                done_q  <= 1'b1;
                            end
                            SQ_SP_LOW: state_q <= SQ_SP_SCL;
                            SQ_SP_SCL: begin
                                state_q <= SQ_IDLE;
                                done_q  <= 1'b1;
                            end
                            default:   state_q <= SQ_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    assign drive = drive_for(state_q);
    assign done  = done_q;
    assign idle  = (state_q == SQ_IDLE);
    assign owned = (state_q == SQ_OWNED);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R1
    sda_setup_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(drive.sda_low) && !drive.scl_low) |-> $past(!drive.scl_low));
endmodule

// File: rtl/i2c_ack_gate.sv
module i2c_ack_gate (
    input  logic clk,
    input  logic rst,
    input  logic ack_halt,
    input  logic ack_valid,
    input  logic ack_bit,
    input  logic clear,
    output logic nack_seen,
    output logic xfer_go
);
    logic nack_q;

    always_ff @(posedge clk) begin
        if (rst || clear)                          nack_q <= 1'b0;
        else if (ack_valid && ack_bit && ack_halt) nack_q <= 1'b1;
    end

    assign nack_seen = nack_q && ack_halt;
    assign xfer_go   = !nack_seen;

    // R9
    nack_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_bit && ack_halt && !clear) |=> nack_q);
    // R9
    nack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (nack_q && !clear) |=> nack_q);
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
    import i2c_cond_pkg::*;
#(
    parameter int unsigned SETUP_CYC   = 4,
    parameter int unsigned HOLD_CYC    = 4,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_master,
    input  logic wr_xmit,
    input  logic wr_ack_halt,
    input  logic wr_bus_busy,
    input  logic wr_no_cond,
    output logic rd_master,
    output logic rd_xmit,
    output logic rd_ack_halt,
    output logic rd_bus_busy,
    output logic rd_no_cond,
    output logic rd_nack_seen,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe,
    output logic sda_oe,
    input  logic ack_valid,
    input  logic ack_bit,
    output logic xfer_go,
    output logic cond_done
);
    ctrl_reg_t   ctrl_q;
    cond_req_e   req;
    line_drive_t drive;
    logic        seq_idle, seq_owned, bus_busy, wr_cmd, start_taken;

    always_ff @(posedge clk) begin
        if (rst)        ctrl_q <= '0;
        else if (wr_en) ctrl_q <= '{master: wr_master, xmit: wr_xmit, ack_halt: wr_ack_halt};
    end

    // Decisions use the mode bits held before this write
    assign wr_cmd = wr_en && !wr_no_cond && ctrl_q.master;

    always_comb begin
        req = REQ_NONE;
        if (wr_cmd && wr_bus_busy && ctrl_q.xmit) begin
            if (seq_owned)                 req = REQ_RESTART;
            else if (seq_idle && !bus_busy) req = REQ_START;
        end else if (wr_cmd && !wr_bus_busy && seq_owned) begin
            req = REQ_STOP;
        end
    end

    assign start_taken = (req == REQ_START) || (req == REQ_RESTART);

    i2c_bus_watch #(.SYNC_STAGES(SYNC_STAGES)) u_watch (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .busy (bus_busy)
    );

    i2c_cond_seq #(.SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .drive(drive),
        .done (cond_done),
        .idle (seq_idle),
        .owned(seq_owned)
    );

    i2c_ack_gate u_ack (
        .clk      (clk),
        .rst      (rst),
        .ack_halt (ctrl_q.ack_halt),
        .ack_valid(ack_valid),
        .ack_bit  (ack_bit),
        .clear    (start_taken),
        .nack_seen(rd_nack_seen),
        .xfer_go  (xfer_go)
    );

    assign scl_oe      = drive.scl_low;
    assign sda_oe      = drive.sda_low;
    assign rd_master   = ctrl_q.master;
    assign rd_xmit     = ctrl_q.xmit;
    assign rd_ack_halt = ctrl_q.ack_halt;
    assign rd_bus_busy = bus_busy;
    assign rd_no_cond  = 1'b1;

    // R4
    no_cond_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && wr_en && wr_no_cond) |=> seq_idle);
    // R5
    slave_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && wr_en && !ctrl_q.master) |=> seq_idle);
    // R5
    slave_owned_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_owned && wr_en && !ctrl_q.master) |=> seq_owned);
endmodule

// File: tb/sim_i2c_cond_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_cond_ctrl;
    localparam int S = 4;
    localparam int H = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic wr_en = 0, wr_master = 0, wr_xmit = 0, wr_ack_halt = 0, wr_bus_busy = 0, wr_no_cond = 1;
    logic rd_master, rd_xmit, rd_ack_halt, rd_bus_busy, rd_no_cond, rd_nack_seen;
    logic scl_i, sda_i, scl_oe, sda_oe, xfer_go, cond_done;
    logic ack_valid = 0, ack_bit = 0;
    logic ext_scl_low = 0, ext_sda_low = 0;

    int n_chk = 0, n_fail = 0;
    bit exp_owned = 0, exp_busy = 0, exp_nack = 0, exp_halt = 0, ext_active = 0;

    always #4 clk = ~clk;

    assign scl_i = !(scl_oe || ext_scl_low);
    assign sda_i = !(sda_oe || ext_sda_low);

    i2c_cond_ctrl #(.SETUP_CYC(S), .HOLD_CYC(H)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_master(wr_master), .wr_xmit(wr_xmit),
        .wr_ack_halt(wr_ack_halt), .wr_bus_busy(wr_bus_busy), .wr_no_cond(wr_no_cond),
        .rd_master(rd_master), .rd_xmit(rd_xmit), .rd_ack_halt(rd_ack_halt),
        .rd_bus_busy(rd_bus_busy), .rd_no_cond(rd_no_cond), .rd_nack_seen(rd_nack_seen),
        .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .ack_valid(ack_valid), .ack_bit(ack_bit), .xfer_go(xfer_go), .cond_done(cond_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input bit m, input bit t, input bit a, input bit b, input bit nc);
        @(negedge clk);
        wr_en = 1; wr_master = m; wr_xmit = t; wr_ack_halt = a; wr_bus_busy = b; wr_no_cond = nc;
        @(posedge clk);
        #1 wr_en = 0;
        exp_halt = a;
    endtask

    // Edges after the write edge until cond_done, -1 if none within limit
    task automatic wait_done(input int limit, output int n);
        int i = 0;
        n = -1;
        while (n < 0 && i < limit) begin
            @(posedge clk); #1;
            i++;
            if (cond_done) n = i;
        end
        if (n > 0) begin
            @(posedge clk); #1;
            chk(!cond_done, "R10 done single cycle", cond_done, 0);
        end
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic check_lines(input string req);
        chk(scl_oe == exp_owned && sda_oe == exp_owned, req, {scl_oe, sda_oe}, {exp_owned, exp_owned});
        chk(rd_bus_busy == exp_busy, {req, " busy"}, rd_bus_busy, exp_busy);
    endtask

    task automatic op_start();
        int n, exp_n;
        if (exp_owned)      exp_n = 2*S + H;   // R2
        else if (!exp_busy) exp_n = S + H;     // R1
        else                exp_n = -1;        // R11
        wr(1, 1, exp_halt, 1, 0);
        wait_done(2*S + H + 4, n);
        chk(n == exp_n, "R1/R2/R11 start latency", n, exp_n);
        if (exp_n > 0) begin
            exp_owned = 1; exp_busy = 1; exp_nack = 0;
        end
        settle();
        check_lines("R1 start lines");
        chk(rd_nack_seen == (exp_nack && exp_halt), "R9 nack after start", rd_nack_seen, exp_nack && exp_halt);
    endtask

    task automatic op_stop();
        int n, exp_n;
        exp_n = exp_owned ? 2*S : -1;          // R3
        wr(1, 1, exp_halt, 0, 0);
        wait_done(2*S + H + 4, n);
        chk(n == exp_n, "R3 stop latency", n, exp_n);
        if (exp_n > 0) begin
            exp_owned = 0; exp_busy = 0;
        end
        settle();
        check_lines("R3 stop lines");
    endtask

    task automatic op_no_cond();
        int n;
        wr(1, 1, exp_halt, 1'($urandom_range(0, 1)), 1);
        wait_done(2*S + H + 4, n);
        chk(n == -1, "R4 no condition", n, -1);
        chk(rd_no_cond == 1'b1, "R4 reads 1", rd_no_cond, 1);
        check_lines("R4 unchanged");
    endtask

    task automatic op_slave();
        int n;
        wr(0, 1, exp_halt, 0, 1);
        wr(0, 1, exp_halt, 1'($urandom_range(0, 1)), 0);
        wait_done(2*S + H + 4, n);
        chk(n == -1, "R5 slave write ignored", n, -1);
        chk(rd_master == 1'b0, "R5 master bit", rd_master, 0);
        check_lines("R5 unchanged");
        wr(1, 1, exp_halt, 0, 1);
    endtask

    task automatic op_no_xmit();
        int n;
        wr(1, 0, exp_halt, 0, 1);
        wr(1, 0, exp_halt, 1, 0);
        wait_done(2*S + H + 4, n);
        chk(n == -1, "R6 start without transmit", n, -1);
        check_lines("R6 unchanged");
        wr(1, 1, exp_halt, 0, 1);
    endtask

    task automatic op_ack(input bit a, input bit b);
        wr(1, 1, a, 0, 1);
        @(negedge clk);
        ack_valid = 1; ack_bit = b;
        @(posedge clk);
        #1 ack_valid = 0;
        if (a && b) exp_nack = 1;
        @(negedge clk);
        chk(rd_nack_seen == (exp_nack && a), a ? "R9 nack flag" : "R8 nack reads 0", rd_nack_seen, exp_nack && a);
        chk(xfer_go == !(exp_nack && a), a ? "R9 halt" : "R8 continue", xfer_go, !(exp_nack && a));
    endtask

    task automatic ext_start();
        @(negedge clk) ext_sda_low = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) ext_scl_low = 1;
        settle();
        exp_busy = 1; ext_active = 1;
        chk(rd_bus_busy == 1'b1, "R7 foreign start", rd_bus_busy, 1);
    endtask

    task automatic ext_stop();
        @(negedge clk) ext_scl_low = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) ext_sda_low = 0;
        settle();
        exp_busy = 0; ext_active = 0;
        chk(rd_bus_busy == 1'b0, "R7 foreign stop", rd_bus_busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R12
        chk(!scl_oe && !sda_oe, "R12 lines released", {scl_oe, sda_oe}, 0);
        chk(!rd_bus_busy && !rd_nack_seen && !cond_done, "R12 flags clear",
            {rd_bus_busy, rd_nack_seen, cond_done}, 0);
        chk(xfer_go && rd_no_cond, "R12 go and no-cond", {xfer_go, rd_no_cond}, 3);

        wr(1, 1, 0, 0, 1);
        op_start();       // R1
        op_start();       // R2
        op_no_cond();     // R4
        op_slave();       // R5
        op_stop();        // R3
        op_stop();        // R3 when not owned
        op_no_xmit();     // R6
        ext_start();      // R7
        op_start();       // R11
        ext_stop();       // R7
        op_ack(0, 1);     // R8
        op_ack(1, 0);     // R9 low ack
        op_ack(1, 1);     // R9
        op_ack(0, 0);     // R8 halt off masks flag
        op_ack(1, 0);     // R9 flag held
        op_start();       // R9 cleared by start

        for (int k = 0; k < 60; k++) begin
            case ($urandom_range(0, 7))
                0: op_start();
                1: op_stop();
                2: op_no_cond();
                3: op_slave();
                4: op_no_xmit();
                5: op_ack(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                6: if (!exp_owned && !exp_busy) ext_start();
                default: if (ext_active) ext_stop();
            endcase
        end
        if (ext_active) ext_stop();
        if (exp_owned) op_stop();
        summary();
    end
endmodule